// File: doc/BRIEF.md
# Segment-Strobed Key Matrix Scanner

This block scans a 16 × 2 key matrix without pins of its own. During a key-scan slot, which the display timing opens after its digit slots, it drives the first sixteen segment lines as source strobes, one at a time, and holds every grid off. For each source it samples the two return lines into a 32-bit shadow register. The shadow becomes the visible key image only when the display timing reports the end of a refresh cycle. A key therefore changes the image at most once per refresh.

A serial front end fetches the image as a byte stream. A read command rewinds an internal byte pointer. The block then presents four bytes, lowest image bits first, on a valid/ready output. The producer holds `out_valid`, `out_data` and `out_last` steady while `out_ready` is low, and advances only on a cycle where both `out_valid` and `out_ready` are high. The consumer may stall for any number of cycles. An end-of-cycle copy that arrives during a read-out waits until the read-out finishes, so the four bytes always come from one image.

Top module: `keymat_scan`

## Requirements
- R1: After reset, `src_strobe` is all zero, `grid_blank` and `out_valid` are low, and the key image reads as four zero bytes.
- R2: A `slot_go` pulse while no scan runs starts a scan in the next cycle. Source k drives `src_strobe[k]` alone for DWELL cycles (default 4), for k = 0 up to 15 in ascending order. Afterwards `src_strobe` returns to zero.
- R3: `grid_blank` is high in exactly those cycles where a source line is strobed.
- R4: A `slot_go` pulse during a running scan has no effect. The strobe sequence continues unchanged and ends at the same cycle.
- R5: Return input r is sampled in the last dwell cycle of source k and stored in shadow bit 2k+r. A closed key reads as 1.
- R6: The key image takes the shadow only on a `cycle_end` pulse. Completing a scan without `cycle_end` leaves the bytes that are read out unchanged.
- R7: One cycle after a `rd_cmd` pulse, `out_valid` is high. Bytes p = 0..3 carry image bits 8p+7..8p. `out_last` is high with byte 3 only. After byte 3 is accepted, `out_valid` is low in the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` do not change.
- R9: A `rd_cmd` pulse during a read-out rewinds the stream to byte 0 in the next cycle.
- R10: A `cycle_end` during a read-out does not change the bytes of that read-out. The copy takes place in the second cycle after the last byte is accepted, so the next read-out returns the new image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_go | input | 1 | Pulse from display timing: key-scan slot begins |
| cycle_end | input | 1 | Pulse from display timing: refresh cycle ends |
| ret_in | input | 2 | Key return lines, high when a key on the strobed source is closed |
| src_strobe | output | 16 | Source strobes, shared with segment outputs 1..16 |
| grid_blank | output | 1 | Holds all grids off during the key-scan slot |
| rd_cmd | input | 1 | Pulse: start (or restart) key image read-out |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready |
| out_data | output | 8 | Key image byte |
| out_last | output | 1 | Marks the fourth and final byte |

## Verification
Faults in the strobe sequencer show at once on `src_strobe` and `grid_blank`. A wrong index or dwell count shifts which source is high in a given cycle, and it also moves keys to the wrong image bits on the next read. A wrong shadow bit mapping or a missed copy appears only on the stream, in the first read-out after the next `cycle_end`. A faulty hold-off appears as a read-out that mixes old and new bytes. A faulty read pointer appears within four handshakes as a misordered byte, a misplaced `out_last` or a stream that fails to stop.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
  typedef enum logic {SCAN_IDLE = 1'b0, SCAN_RUN = 1'b1} scan_state_e;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/keymat_strobe.sv
module keymat_strobe
  import keymat_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned N_RET = 2,
  parameter int unsigned DWELL = 4,
  localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned DW_W  = (DWELL > 1) ? $clog2(DWELL) : 1,
  localparam int unsigned KEY_W = N_SRC * N_RET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_go,
  input  logic [N_RET-1:0] ret_in,
  output logic [N_SRC-1:0] src_strobe,
  output logic             scanning,
  output logic [KEY_W-1:0] shadow
);
  scan_state_e      state_q;
  logic [SRC_W-1:0] idx_q;
  logic [DW_W-1:0]  dwell_q;
  logic             dwell_end;

  assign dwell_end = (dwell_q == DW_W'(DWELL - 1));
  assign scanning  = (state_q == SCAN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
      dwell_q <= '0;
    end else if (state_q == SCAN_IDLE) begin
      if (slot_go) begin
        state_q <= SCAN_RUN;
        idx_q   <= '0;
        dwell_q <= '0;
      end
    end else if (dwell_end) begin
      dwell_q <= '0;
      if (idx_q == SRC_W'(N_SRC - 1)) begin
        state_q <= SCAN_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (scanning && dwell_end) begin
      for (int k = 0; k < int'(N_SRC); k++) begin
        if (idx_q == SRC_W'(k)) begin
          for (int r = 0; r < int'(N_RET); r++) begin
            shadow[k*N_RET + r] <= ret_in[r];
          end
        end
      end
    end
  end

  for (genvar g = 0; g < int'(N_SRC); g++) begin : g_strobe
    assign src_strobe[g] = scanning && (idx_q == SRC_W'(g));
  end
endmodule

// File: rtl/keymat_image.sv
module keymat_image #(
  parameter int unsigned KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_end,
  input  logic             hold,
  input  logic [KEY_W-1:0] shadow,
  output logic [KEY_W-1:0] image
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      image     <= '0;
      pending_q <= 1'b0;
    end else if (cycle_end || pending_q) begin
      if (hold) begin
        pending_q <= 1'b1;
      end else begin
        image     <= shadow;
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/keymat_reader.sv
module keymat_reader
  import keymat_pkg::*;
#(
  parameter int unsigned KEY_W = 32,
  localparam int unsigned NBYTES = KEY_W / BYTE_W,
  localparam int unsigned PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [KEY_W-1:0]  image,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  logic             active_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (rd_cmd) begin
      active_q <= 1'b1;
      ptr_q    <= '0;
    end else if (active_q && out_ready) begin
      if (out_last) begin
        active_q <= 1'b0;
        ptr_q    <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign busy      = active_q;
  assign out_valid = active_q;
  assign out_last  = active_q && (ptr_q == PTR_W'(NBYTES - 1));
  assign out_data  = image[BYTE_W*ptr_q +: BYTE_W];
endmodule

// File: rtl/keymat_scan.sv
module keymat_scan
  import keymat_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned N_RET = 2,
  parameter int unsigned DWELL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_go,
  input  logic             cycle_end,
  input  logic [N_RET-1:0] ret_in,
  output logic [N_SRC-1:0] src_strobe,
  output logic             grid_blank,
  input  logic             rd_cmd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int unsigned KEY_W = N_SRC * N_RET;

  logic [KEY_W-1:0] shadow;
  logic [KEY_W-1:0] image;
  logic             scanning;
  logic             rd_busy;

  keymat_strobe #(.N_SRC(N_SRC), .N_RET(N_RET), .DWELL(DWELL)) u_strobe (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .ret_in(ret_in),
    .src_strobe(src_strobe), .scanning(scanning), .shadow(shadow)
  );

  keymat_image #(.KEY_W(KEY_W)) u_image (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .hold(rd_busy),
    .shadow(shadow), .image(image)
  );

  keymat_reader #(.KEY_W(KEY_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .image(image), .busy(rd_busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  assign grid_blank = scanning;
endmodule

// File: rtl/keymat_scan_chk.sv
module keymat_scan_chk #(
  parameter int unsigned N_SRC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_cmd,
  input logic [N_SRC-1:0] src_strobe,
  input logic             grid_blank,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last
);
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_strobe));

  a_r3_blank_tracks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    grid_blank == (src_strobe != '0));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rd_cmd) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  a_r7_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !rd_cmd) |=> !out_valid);

  a_r9_cmd_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (out_valid && !out_last));

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind keymat_scan keymat_scan_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .src_strobe(src_strobe),
  .grid_blank(grid_blank), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/keymat_scan_tb_top.sv
`timescale 1ns/1ps
module keymat_scan_tb_top;
  localparam int N_SRC = 16;
  localparam int N_RET = 2;
  localparam int DWELL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_go = 1'b0, cycle_end = 1'b0, rd_cmd = 1'b0, out_ready = 1'b0;
  logic [N_RET-1:0] ret_in;
  logic [N_SRC-1:0] src_strobe;
  logic grid_blank, out_valid, out_last;
  logic [7:0] out_data;
  logic [31:0] pressed = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  // key matrix model: a closed key links its source to its return line
  always_comb begin
    for (int r = 0; r < N_RET; r++) begin
      ret_in[r] = 1'b0;
      for (int k = 0; k < N_SRC; k++)
        ret_in[r] = ret_in[r] | (src_strobe[k] & pressed[k*N_RET + r]);
    end
  end

  keymat_scan #(.N_SRC(N_SRC), .N_RET(N_RET), .DWELL(DWELL)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .cycle_end(cycle_end),
    .ret_in(ret_in), .src_strobe(src_strobe), .grid_blank(grid_blank),
    .rd_cmd(rd_cmd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan_keys(input logic [31:0] pat);
    pressed = pat;
    @(negedge clk) slot_go = 1'b1;
    @(negedge clk) slot_go = 1'b0;
    repeat (N_SRC*DWELL + 1) @(negedge clk);
  endtask

  task automatic end_cycle();
    @(negedge clk) cycle_end = 1'b1;
    @(negedge clk) cycle_end = 1'b0;
  endtask

  // read four bytes; optionally stall on byte 0 and raise cycle_end there
  task automatic read_expect(input logic [31:0] exp, input bit inject,
                             input string req);
    @(negedge clk) rd_cmd = 1'b1;
    @(negedge clk) rd_cmd = 1'b0;
    out_ready = 1'b1;
    for (int p = 0; p < 4; p++) begin
      if (inject && p == 0) begin
        out_ready = 1'b0;
        cycle_end = 1'b1;
        @(negedge clk) cycle_end = 1'b0;
        chk(out_valid && out_data == exp[7:0] && !out_last, "R8 stall",
            {23'd0, out_valid, out_data}, {24'd1, exp[7:0]});
        out_ready = 1'b1;
      end
      chk(out_valid === 1'b1, req, {31'd0, out_valid}, 32'd1);
      chk(out_data === exp[8*p +: 8], req, {24'd0, out_data}, {24'd0, exp[8*p +: 8]});
      chk(out_last === (p == 3), "R7 last", {31'd0, out_last}, {31'd0, p == 3});
      @(negedge clk);
    end
    chk(out_valid === 1'b0, "R7 end", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(src_strobe === '0, "R1 strobe", {16'd0, src_strobe}, 32'd0);
    chk(grid_blank === 1'b0, "R1 blank", {31'd0, grid_blank}, 32'd0);
    chk(out_valid === 1'b0, "R1 valid", {31'd0, out_valid}, 32'd0);
    read_expect(32'h0, 1'b0, "R1 image");
  endtask

  task automatic t_sequence();
    pressed = '0;
    @(negedge clk) slot_go = 1'b1;
    @(negedge clk) slot_go = 1'b0;
    for (int c = 0; c < N_SRC*DWELL; c++) begin
      if (c > 0) @(negedge clk);
      slot_go = 1'b0;
      chk(src_strobe === (16'd1 << (c / DWELL)), "R2 order",
          {16'd0, src_strobe}, 32'd1 << (c / DWELL));
      chk(grid_blank === 1'b1, "R3 blank on", {31'd0, grid_blank}, 32'd1);
      if (c == 21) slot_go = 1'b1; // R4: ignored mid-scan
    end
    @(negedge clk);
    chk(src_strobe === '0, "R4 ends on time", {16'd0, src_strobe}, 32'd0);
    chk(grid_blank === 1'b0, "R3 blank off", {31'd0, grid_blank}, 32'd0);
  endtask

  task automatic t_patterns();
    scan_keys(32'hA5C3_0F81); end_cycle();
    read_expect(32'hA5C3_0F81, 1'b0, "R5 pattern A");
    scan_keys(32'h8000_0001); end_cycle();
    read_expect(32'h8000_0001, 1'b0, "R5 corner keys");
    scan_keys(32'h5555_AAAA); end_cycle();
    read_expect(32'h5555_AAAA, 1'b0, "R5 alternating");
  endtask

  task automatic t_no_copy();
    scan_keys(32'h1234_5678);
    read_expect(32'h5555_AAAA, 1'b0, "R6 no cycle_end");
  endtask

  task automatic t_holdoff();
    // shadow now 1234_5678, image 5555_AAAA
    read_expect(32'h5555_AAAA, 1'b1, "R10 consistent");
    @(negedge clk);
    read_expect(32'h1234_5678, 1'b0, "R10 deferred copy");
  endtask

  task automatic t_restart();
    @(negedge clk) rd_cmd = 1'b1;
    @(negedge clk) rd_cmd = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_data === 8'h34, "R9 before restart", {24'd0, out_data}, 32'h34);
    out_ready = 1'b0;
    rd_cmd = 1'b1;
    @(negedge clk) rd_cmd = 1'b0;
    chk(out_valid && out_data === 8'h78 && !out_last, "R9 rewound",
        {23'd0, out_valid, out_data}, 32'h178);
    out_ready = 1'b1;
    for (int p = 0; p < 4; p++) @(negedge clk);
    chk(out_valid === 1'b0, "R9 completes", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_patterns();
    t_no_copy();
    t_holdoff();
    t_restart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule